// File: doc/BRIEF.md
# Job Queue with Ordering Choice and Wait Statistics

This block holds one queue of jobs. Each entry keeps a job number, a user information word and the cycle on which the job arrived. An initialise command sets the pop order and an active length. The pop order is either oldest-first (FIFO, type 1) or newest-first (LIFO, type 2). The active length may be smaller than the compile-time storage depth. Add, remove and full-query commands then act on the queue. Every command returns a 3-bit status code one cycle after it is accepted.

A separate statistics port reports one metric per request, chosen by a 3-bit code. The metrics are the occupancy, the peak occupancy, the shortest finished wait, the age of the oldest waiting job, the mean gap between arrivals and the mean finished wait. All times are in clock cycles, taken from a free-running cycle counter. The two means come from a sequential restoring divider. While that divider runs, both the command port and the statistics port hold their ready signals low. This keeps each mean consistent with the queue state at the moment it was requested.

Top module: `job_queue_stats`

## Requirements
- R1: After reset, rsp_valid and stat_valid are low and op_ready is high. Until an initialise succeeds, every add, remove and full query returns status 2, and every statistics request returns value 0 with status 2.
- R2: An initialise with op_type 1 configures oldest-first order and op_type 2 configures newest-first order, returning status 0. Any other op_type returns status 4 and leaves the queue unconfigured, so later adds return status 2.
- R3: An initialise with a valid type but a length of zero or less (op_len is signed) returns status 5. A length above DEPTH returns status 7. Either way the queue is left unconfigured.
- R4: A command is accepted on a clock edge where op_valid and op_ready are both high. The edge after acceptance raises rsp_valid for exactly one cycle with its status. Status 0 means success. Op codes: 0 initialise, 1 add, 2 remove, 3 full query.
- R5: In oldest-first mode, a remove returns the job and information pair of the earliest-added entry still queued.
- R6: In newest-first mode, a remove returns the pair of the most recently added entry still queued.
- R7: An add while the occupancy equals the configured length returns status 1 and stores nothing. A remove from an empty queue returns status 3.
- R8: A full query returns status 1 when the occupancy equals the configured length, and status 0 otherwise.
- R9: Statistic code 1 returns the current occupancy. Code 3 returns the highest occupancy reached since the last successful initialise.
- R10: Statistic code 2 returns (arrival cycle of the last add minus arrival cycle of the first add) divided by (number of adds minus 1), truncated toward zero. It returns 0 when fewer than two adds have succeeded.
- R11: Statistic code 6 returns the summed waits of removed jobs divided by their count, truncated; a wait runs from the add cycle to the remove cycle. Code 4 returns the smallest such wait. Both return 0 when nothing has been removed.
- R12: Statistic code 5 returns the request cycle minus the arrival cycle of the oldest job still queued, or 0 when the queue is empty.
- R13: Statistic codes 0 and 7 return value 0 with status 4. While a divide is running, op_ready and stat_ready are low.
- R14: A statistic that needs no divide is presented with stat_valid on the edge after acceptance. A divided statistic is presented with stat_valid and status 0 when the quotient is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Command request |
| op_ready | output | 1 | Command can be accepted |
| op_code | input | 2 | 0 initialise, 1 add, 2 remove, 3 full query |
| op_type | input | 3 | Ordering for initialise: 1 oldest-first, 2 newest-first |
| op_len | input | LEN_W+1 | Signed active length for initialise |
| op_job | input | JOB_W | Job number to add |
| op_info | input | INFO_W | Information word to add |
| rsp_valid | output | 1 | Command response strobe |
| rsp_status | output | 3 | Command status code |
| rsp_job | output | JOB_W | Job number of the removed entry |
| rsp_info | output | INFO_W | Information word of the removed entry |
| stat_req | input | 1 | Statistics request |
| stat_ready | output | 1 | Statistics request can be accepted |
| stat_code | input | 3 | Metric selector |
| stat_valid | output | 1 | Metric result strobe |
| stat_status | output | 3 | Metric status code |
| stat_value | output | SUM_W | Metric value in cycles or entries |

## Verification
The hardest situation to reach is in newest-first mode. There, the entry that sets the oldest-waiting age stays buried at the bottom while newer entries come and go above it. A mean request must also arrive while the command stream is busy.

The stimulus mixes directed sequences with randomised runs. Directed sequences fill a short queue, overfill it, drain it and read every code. Randomised runs switch between the two orders, vary the idle gaps between commands and issue statistics requests between commands. The bench keeps its own cycle count and queue model, so ages, minimum waits and truncated means are predicted whatever the interleaving. Every divided request is also checked for the stall on both ready outputs.

// File: rtl/jq_pkg.sv
package jq_pkg;

  typedef enum logic [1:0] {
    OP_INIT = 2'd0,
    OP_ADD  = 2'd1,
    OP_REM  = 2'd2,
    OP_FULL = 2'd3
  } jq_op_e;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_FULL    = 3'd1,
    ST_UNDEF   = 3'd2,
    ST_EMPTY   = 3'd3,
    ST_BADCODE = 3'd4,
    ST_BADLEN  = 3'd5,
    ST_NOROOM  = 3'd7
  } jq_status_e;

  localparam logic [2:0] ORDER_OLDEST = 3'd1;
  localparam logic [2:0] ORDER_NEWEST = 3'd2;

endpackage

// File: rtl/jq_store.sv
// Circular entry store that can release from either end.
module jq_store #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop_front,
  input  logic          pop_back,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  front,
  output logic [W-1:0]  back,
  output logic [CW-1:0] occ
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] head, tail, tail_prev;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] prv(input logic [PW-1:0] p);
    return (p == '0) ? PW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign tail_prev = prv(tail);
  assign front     = mem[head];
  assign back      = mem[tail_prev];

  always_ff @(posedge clk) begin
    if (push && !clr) mem[tail] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (clr) begin
      head <= '0;
      tail <= '0;
      occ  <= '0;
    end else if (push) begin
      tail <= nxt(tail);
      occ  <= occ + 1'b1;
    end else if (pop_front) begin
      head <= nxt(head);
      occ  <= occ - 1'b1;
    end else if (pop_back) begin
      tail <= tail_prev;
      occ  <= occ - 1'b1;
    end
  end
endmodule

// File: rtl/jq_divider.sv
// Restoring divider, one quotient bit per cycle.
module jq_divider #(
  parameter int NW = 32,
  parameter int DW = 16,
  localparam int CW = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quot
);
  logic [DW:0]   rem, shifted;
  logic [DW-1:0] dvs;
  logic [CW-1:0] left;
  logic          fits;

  assign shifted = {rem[DW-1:0], quot[NW-1]};
  assign fits    = shifted >= {1'b0, dvs};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quot <= '0;
      rem  <= '0;
      dvs  <= '0;
      left <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quot <= num;
        rem  <= '0;
        dvs  <= den;
        left <= CW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= fits ? shifted - {1'b0, dvs} : shifted;
        quot <= {quot[NW-2:0], fits};
        left <= left - 1'b1;
        if (left == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/job_queue_stats.sv
module job_queue_stats
  import jq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int JOB_W  = 8,
  parameter int INFO_W = 16,
  parameter int TS_W   = 24,
  parameter int CNT_W  = 16,
  parameter int SUM_W  = 32,
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    op_valid,
  output logic                    op_ready,
  input  logic [1:0]              op_code,
  input  logic [2:0]              op_type,
  input  logic signed [LEN_W:0]   op_len,
  input  logic [JOB_W-1:0]        op_job,
  input  logic [INFO_W-1:0]       op_info,
  output logic                    rsp_valid,
  output logic [2:0]              rsp_status,
  output logic [JOB_W-1:0]        rsp_job,
  output logic [INFO_W-1:0]       rsp_info,
  input  logic                    stat_req,
  output logic                    stat_ready,
  input  logic [2:0]              stat_code,
  output logic                    stat_valid,
  output logic [2:0]              stat_status,
  output logic [SUM_W-1:0]        stat_value
);
  localparam int EW = TS_W + JOB_W + INFO_W;

  function automatic logic [TS_W-1:0] f_elapsed(input logic [TS_W-1:0] now_t,
                                                input logic [TS_W-1:0] then_t);
    return now_t - then_t;
  endfunction

  function automatic logic [TS_W-1:0] f_min(input logic [TS_W-1:0] a,
                                            input logic [TS_W-1:0] b);
    return (a < b) ? a : b;
  endfunction

  // state
  logic [TS_W-1:0]  cyc_q, first_q, last_q, min_wait_q;
  logic             cfg_q, lifo_q;
  logic [LEN_W-1:0] len_q, peak_q;
  logic [CNT_W-1:0] n_add_q, n_rem_q;
  logic [SUM_W-1:0] wait_sum_q;

  // named internal events
  logic             op_fire, stat_fire, is_full;
  logic             init_ok, init_bad, push, pop_f, pop_b, popping;
  logic [2:0]       st_n;
  logic [EW-1:0]    front, back, taken;
  logic [LEN_W-1:0] occ;
  logic [TS_W-1:0]  rm_wait, oldest_age;
  logic             div_busy, div_done, div_start;
  logic [SUM_W-1:0] div_num, div_quot, imm_val;
  logic [CNT_W-1:0] div_den;
  logic [2:0]       imm_st;

  assign op_ready   = !div_busy;
  assign stat_ready = !div_busy;
  assign op_fire    = op_valid && op_ready;
  assign stat_fire  = stat_req && stat_ready;
  assign is_full    = (occ == len_q);
  assign popping    = pop_f || pop_b;
  assign taken      = lifo_q ? back : front;
  assign rm_wait    = f_elapsed(cyc_q, taken[EW-1 -: TS_W]);
  assign oldest_age = f_elapsed(cyc_q, front[EW-1 -: TS_W]);

  jq_store #(.DEPTH(DEPTH), .W(EW)) u_store (
    .clk(clk), .rst_n(rst_n), .clr(init_ok || init_bad), .push(push),
    .pop_front(pop_f), .pop_back(pop_b), .wdata({cyc_q, op_job, op_info}),
    .front(front), .back(back), .occ(occ)
  );

  jq_divider #(.NW(SUM_W), .DW(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num), .den(div_den),
    .busy(div_busy), .done(div_done), .quot(div_quot)
  );

  // command decode
  always_comb begin
    st_n = ST_OK; init_ok = 1'b0; init_bad = 1'b0;
    push = 1'b0; pop_f = 1'b0; pop_b = 1'b0;
    if (op_fire) begin
      unique case (jq_op_e'(op_code))
        OP_INIT: begin
          init_bad = 1'b1;
          if (op_type != ORDER_OLDEST && op_type != ORDER_NEWEST) st_n = ST_BADCODE;
          else if (op_len <= 0)                                   st_n = ST_BADLEN;
          else if (op_len > DEPTH)                                st_n = ST_NOROOM;
          else begin init_bad = 1'b0; init_ok = 1'b1; end
        end
        OP_ADD: begin
          if (!cfg_q)       st_n = ST_UNDEF;
          else if (is_full) st_n = ST_FULL;
          else              push = 1'b1;
        end
        OP_REM: begin
          if (!cfg_q)          st_n = ST_UNDEF;
          else if (occ == '0)  st_n = ST_EMPTY;
          else if (lifo_q)     pop_b = 1'b1;
          else                 pop_f = 1'b1;
        end
        OP_FULL: begin
          if (!cfg_q) st_n = ST_UNDEF;
          else        st_n = is_full ? ST_FULL : ST_OK;
        end
      endcase
    end
  end

  // statistics decode
  always_comb begin
    imm_val = '0; imm_st = ST_OK; div_start = 1'b0;
    div_num = '0; div_den = '0;
    if (!cfg_q) imm_st = ST_UNDEF;
    else begin
      unique case (stat_code)
        3'd1: imm_val = SUM_W'(occ);
        3'd3: imm_val = SUM_W'(peak_q);
        3'd4: imm_val = (n_rem_q != '0) ? SUM_W'(min_wait_q) : '0;
        3'd5: imm_val = (occ != '0) ? SUM_W'(oldest_age) : '0;
        3'd2: if (n_add_q >= CNT_W'(2)) begin
                div_start = stat_fire;
                div_num   = SUM_W'(f_elapsed(last_q, first_q));
                div_den   = n_add_q - 1'b1;
              end
        3'd6: if (n_rem_q != '0) begin
                div_start = stat_fire;
                div_num   = wait_sum_q;
                div_den   = n_rem_q;
              end
        default: imm_st = ST_BADCODE;
      endcase
    end
  end

  logic             imm_v_q;
  logic [SUM_W-1:0] imm_val_q;
  logic [2:0]       imm_st_q;

  assign stat_valid  = imm_v_q || div_done;
  assign stat_value  = div_done ? div_quot : imm_val_q;
  assign stat_status = div_done ? 3'(ST_OK) : imm_st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0; cfg_q <= 1'b0; lifo_q <= 1'b0; len_q <= '0; peak_q <= '0;
      n_add_q <= '0; n_rem_q <= '0; first_q <= '0; last_q <= '0;
      min_wait_q <= '0; wait_sum_q <= '0;
      rsp_valid <= 1'b0; rsp_status <= '0; rsp_job <= '0; rsp_info <= '0;
      imm_v_q <= 1'b0; imm_val_q <= '0; imm_st_q <= '0;
    end else begin
      cyc_q      <= cyc_q + 1'b1;
      rsp_valid  <= op_fire;
      rsp_status <= st_n;
      rsp_job    <= popping ? taken[JOB_W+INFO_W-1 -: JOB_W] : '0;
      rsp_info   <= popping ? taken[INFO_W-1:0] : '0;
      imm_v_q    <= stat_fire && !div_start;
      imm_val_q  <= imm_val;
      imm_st_q   <= imm_st;
      if (init_bad) cfg_q <= 1'b0;
      if (init_ok) begin
        cfg_q <= 1'b1; lifo_q <= (op_type == ORDER_NEWEST);
        len_q <= op_len[LEN_W-1:0]; peak_q <= '0;
        n_add_q <= '0; n_rem_q <= '0; first_q <= '0; last_q <= '0;
        min_wait_q <= '0; wait_sum_q <= '0;
      end
      if (push) begin
        n_add_q <= n_add_q + 1'b1;
        if (n_add_q == '0) first_q <= cyc_q;
        last_q <= cyc_q;
        if (occ + 1'b1 > peak_q) peak_q <= occ + 1'b1;
      end
      if (popping) begin
        n_rem_q    <= n_rem_q + 1'b1;
        wait_sum_q <= wait_sum_q + SUM_W'(rm_wait);
        min_wait_q <= (n_rem_q == '0) ? rm_wait : f_min(rm_wait, min_wait_q);
      end
    end
  end
endmodule

// File: rtl/jq_checker.sv
module jq_checker #(
  parameter int LEN_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_code,
  input logic             cfg,
  input logic [LEN_W-1:0] occ,
  input logic [LEN_W-1:0] len,
  input logic [LEN_W-1:0] peak,
  input logic             div_busy,
  input logic             stat_ready,
  input logic             rsp_valid,
  input logic [2:0]       rsp_status
);
  logic acc;
  assign acc = op_valid && op_ready;

  p_rsp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_rsp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  p_undefined_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg && op_code != 2'd0) |=> rsp_status == 3'd2);
  p_full_no_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg && op_code == 2'd1 && occ == len) |=> (rsp_status == 3'd1 && occ == $past(occ)));
  p_empty_remove_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cfg && op_code == 2'd2 && occ == '0) |=> rsp_status == 3'd3);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg |-> occ <= len);
  p_peak_covers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg |-> peak >= occ);
  p_stall_r13: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (!op_ready && !stat_ready));
endmodule

bind job_queue_stats jq_checker #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
  .op_code(op_code), .cfg(cfg_q), .occ(occ), .len(len_q), .peak(peak_q),
  .div_busy(div_busy), .stat_ready(stat_ready), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status)
);

// File: tb/job_queue_stats_tb.sv
module job_queue_stats_tb;
  localparam int DEPTH = 8, JOB_W = 8, INFO_W = 16, SUM_W = 32;
  localparam int LEN_W = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_ready, rsp_valid, stat_req = 0, stat_ready, stat_valid;
  logic [1:0] op_code = 0;
  logic [2:0] op_type = 0, rsp_status, stat_code = 0, stat_status;
  logic signed [LEN_W:0] op_len = 0;
  logic [JOB_W-1:0] op_job = 0, rsp_job;
  logic [INFO_W-1:0] op_info = 0, rsp_info;
  logic [SUM_W-1:0] stat_value;

  always #10 clk = ~clk;

  job_queue_stats #(.DEPTH(DEPTH), .JOB_W(JOB_W), .INFO_W(INFO_W)) u_dut (.*);

  int checks = 0, fails = 0;
  longint tb_now = 0;
  always @(posedge clk) if (rst_n) tb_now <= tb_now + 1;

  // reference model
  bit m_cfg = 0, m_lifo = 0;
  int m_len = 0, m_peak = 0, m_nadd = 0, m_nrem = 0;
  longint m_first = 0, m_last = 0, m_wsum = 0, m_minw = 0;
  int mj[$], mi[$];
  longint mt[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic void m_clear();
    mj.delete(); mi.delete(); mt.delete();
    m_peak = 0; m_nadd = 0; m_nrem = 0; m_first = 0; m_last = 0; m_wsum = 0; m_minw = 0;
  endfunction

  function automatic longint mean_of(input longint tot, input longint n);
    return (n <= 0) ? 0 : tot / n;
  endfunction

  task automatic op(input int code, input int typ, input int len, input int job, input int info);
    longint stamp, w;
    int exp_st, ej, ei;
    string tag;
    op_valid = 1; op_code = code[1:0]; op_type = typ[2:0];
    op_len = len[LEN_W:0]; op_job = job[JOB_W-1:0]; op_info = info[INFO_W-1:0];
    while (!op_ready) @(negedge clk);
    stamp = tb_now;
    @(negedge clk);
    op_valid = 0;
    exp_st = 0; ej = 0; ei = 0; tag = "R4";
    case (code)
      0: begin
        tag = "R2";
        if (typ != 1 && typ != 2) exp_st = 4;
        else if (len <= 0) begin exp_st = 5; tag = "R3"; end
        else if (len > DEPTH) begin exp_st = 7; tag = "R3"; end
        m_clear();
        m_cfg = (exp_st == 0);
        if (m_cfg) begin m_lifo = (typ == 2); m_len = len; end
      end
      1: begin
        if (!m_cfg) begin exp_st = 2; tag = "R1"; end
        else if (mj.size() == m_len) begin exp_st = 1; tag = "R7"; end
        else begin
          mj.push_back(job & 8'hff); mi.push_back(info & 16'hffff); mt.push_back(stamp);
          if (m_nadd == 0) m_first = stamp;
          m_last = stamp; m_nadd++;
          if (mj.size() > m_peak) m_peak = mj.size();
        end
      end
      2: begin
        if (!m_cfg) begin exp_st = 2; tag = "R1"; end
        else if (mj.size() == 0) begin exp_st = 3; tag = "R7"; end
        else begin
          if (m_lifo) begin ej = mj.pop_back(); ei = mi.pop_back(); w = stamp - mt.pop_back(); tag = "R6"; end
          else begin ej = mj.pop_front(); ei = mi.pop_front(); w = stamp - mt.pop_front(); tag = "R5"; end
          if (m_nrem == 0 || w < m_minw) m_minw = w;
          m_wsum += w; m_nrem++;
        end
      end
      default: begin
        tag = "R8";
        if (!m_cfg) begin exp_st = 2; tag = "R1"; end
        else exp_st = (mj.size() == m_len) ? 1 : 0;
      end
    endcase
    chk("R4", "rsp_valid", rsp_valid, 1);
    chk(tag, "rsp_status", rsp_status, exp_st);
    if (code == 2 && exp_st == 0) begin
      chk(tag, "rsp_job", rsp_job, ej);
      chk(tag, "rsp_info", rsp_info, ei);
    end
  endtask

  task automatic stat(input int code);
    longint stamp, ev;
    int est, waited;
    bit divides;
    string tag;
    stat_req = 1; stat_code = code[2:0];
    while (!stat_ready) @(negedge clk);
    stamp = tb_now;
    ev = 0; est = 0; divides = 0;
    case (code)
      1: begin ev = mj.size(); tag = "R9"; end
      3: begin ev = m_peak; tag = "R9"; end
      2: begin ev = mean_of(m_last - m_first, m_nadd - 1); divides = (m_nadd >= 2); tag = "R10"; end
      4: begin ev = (m_nrem > 0) ? m_minw : 0; tag = "R11"; end
      6: begin ev = mean_of(m_wsum, m_nrem); divides = (m_nrem > 0); tag = "R11"; end
      5: begin ev = (mj.size() > 0) ? stamp - mt[0] : 0; tag = "R12"; end
      default: begin est = 4; tag = "R13"; end
    endcase
    if (!m_cfg) begin ev = 0; est = 2; divides = 0; tag = "R1"; end
    @(negedge clk);
    stat_req = 0;
    if (divides) begin
      chk("R13", "op_ready during divide", op_ready, 0);
      chk("R13", "stat_ready during divide", stat_ready, 0);
    end else chk("R14", "stat_valid next cycle", stat_valid, 1);
    waited = 0;
    while (!stat_valid && waited < 80) begin @(negedge clk); waited++; end
    chk(tag, "stat_valid", stat_valid, 1);
    chk(tag, "stat_value", stat_value, ev);
    chk(tag, "stat_status", stat_status, est);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: act=expired exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    chk("R1", "stat_valid in reset", stat_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "op_ready after reset", op_ready, 1);
    op(1, 0, 0, 5, 55);
    op(3, 0, 0, 0, 0);
    stat(1);
    op(0, 3, 4, 0, 0);
    op(1, 0, 0, 6, 66);
    op(0, 1, 0, 0, 0);
    op(0, 1, -2, 0, 0);
    op(0, 2, DEPTH + 1, 0, 0);
    op(2, 0, 0, 0, 0);
    // oldest-first, length 3
    op(0, 1, 3, 0, 0);
    stat(2); stat(6); stat(4); stat(5);
    op(2, 0, 0, 0, 0);
    op(3, 0, 0, 0, 0);
    op(1, 0, 0, 8'h11, 16'hA001);
    repeat (4) @(negedge clk);
    op(1, 0, 0, 8'h22, 16'hA002);
    repeat (7) @(negedge clk);
    op(1, 0, 0, 8'h33, 16'hA003);
    op(3, 0, 0, 0, 0);
    op(1, 0, 0, 8'h44, 16'hA004);
    stat(1); stat(3); stat(5); stat(2);
    op(2, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    op(2, 0, 0, 0, 0);
    op(2, 0, 0, 0, 0);
    stat(3); stat(4); stat(6); stat(1); stat(5);
    // newest-first, full depth
    op(0, 2, DEPTH, 0, 0);
    for (int k = 0; k < 5; k++) begin op(1, 0, 0, 16 + k, 300 + k); @(negedge clk); end
    stat(5);
    op(2, 0, 0, 0, 0);
    op(2, 0, 0, 0, 0);
    stat(5); stat(4);
    stat(7); stat(0);
    // random phase
    for (int n = 0; n < 1500; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 2)       op(0, $urandom_range(1, 2), $urandom_range(1, DEPTH), 0, 0);
      else if (r < 3)  op(0, $urandom_range(0, 7), $urandom_range(0, DEPTH + 3) - 1, 0, 0);
      else if (r < 45) op(1, 0, 0, $urandom_range(0, 255), $urandom_range(0, 65535));
      else if (r < 80) op(2, 0, 0, 0, 0);
      else if (r < 85) op(3, 0, 0, 0, 0);
      else             stat($urandom_range(0, 7));
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule